// File: doc/BRIEF.md
# Interrupt Polarity and Latch Controller

This block sits between a set of peripheral interrupt sources and a parent interrupt controller that accepts only active-high level requests. Each source line can be masked, have its sense inverted, and be configured as level or edge. Edge requests are captured in a per-line latch, so the parent always sees a steady high level until software acknowledges the request. Arbitration, routing and affinity stay in the parent.

Software reaches the block through a simple register port with a byte address, 16-bit write data and a combinational read path. Each register group holds 16 line bits per word, and consecutive words are 4 bytes apart. A per-instance parameter decides whether the acknowledge group exists at all. When it is absent, an edge latch can only be dropped by switching its line to level mode.

Top module: `irq_level_bridge`

## Requirements
- R1: After a synchronous reset every line is masked, polarity is normal, every line is in level mode, every latch is clear and every output is 0.
- R2: Byte address bits [5:4] select the group (0 mask, 1 polarity, 2 acknowledge, 3 mode) and bits [3:2] select the word. Line n is bit n%16 of word n/16. A write whose address has bits [1:0] nonzero or bits [7:6] nonzero changes nothing, and a read from such an address returns 0.
- R3: Reads of the mask, polarity and mode groups return the stored bits. Bits for lines at or above NUM_LINES read 0, and the acknowledge group always reads 0.
- R4: A mask bit of 1 holds that line's output at 0. A mask bit of 0 lets the line through.
- R5: In level mode (mode bit 0) the output equals the source XOR the polarity bit, gated by the mask, in the same cycle and without a clock edge.
- R6: In edge mode (mode bit 1), a 0-to-1 change of source XOR polarity, seen between two clock edges, sets the line's latch at the second edge. The output then stays high after the source returns to idle.
- R7: An edge sets the latch even while the line is masked. The held request appears on the output as soon as the mask bit is cleared.
- R8: Writing 1 to a line's acknowledge bit clears its latch at that clock edge, and 0 bits have no effect. If a new edge and an acknowledge arrive on the same edge, the latch stays set.
- R9: With HAS_ACK = 0, writes to the acknowledge group have no effect and an edge latch holds its request.
- R10: A line in level mode keeps its latch clear, so a request held before a switch to level mode is gone when the line returns to edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_LINES | Raw interrupt inputs from peripherals |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_out | output | NUM_LINES | Active-high level requests to the parent |

## Verification
Directed sequences drive single lines through level, edge, masked-edge and acknowledge cases. They separate an edge that is latched from a level that only passes through, and they show whether an acknowledge that lands together with a new edge loses that edge. A long constrained-random run mixes writes to all four groups, some of them to malformed addresses, with random toggling on all lines. This exercises polarity flips that produce edges, mask changes over held requests, and words that are only partly populated. A second instance without the acknowledge group shows that the latch holds through acknowledge writes and clears only through a switch to level mode.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int unsigned LINES_PER_WORD = 16;
    localparam int unsigned MAX_LINES      = 64;
    localparam int unsigned ADDR_W         = 8;
    localparam int unsigned DATA_W         = 16;

    typedef enum logic [1:0] {
        GRP_MASK = 2'd0,
        GRP_POL  = 2'd1,
        GRP_ACK  = 2'd2,
        GRP_MODE = 2'd3
    } grp_e;

    typedef struct packed {
        logic       valid;
        grp_e       grp;
        logic [1:0] word;
    } reg_dec_t;

    typedef struct packed {
        logic mask;
        logic pol;
        logic edge_mode;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{mask: 1'b1, pol: 1'b0, edge_mode: 1'b0};

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.valid = (a[7:6] == 2'b00) && (a[1:0] == 2'b00);
        d.grp   = grp_e'(a[5:4]);
        d.word  = a[3:2];
        return d;
    endfunction

endpackage

// File: rtl/irqb_regs.sv
module irqb_regs
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter bit          HAS_ACK   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output line_cfg_t            cfg [NUM_LINES],
    output logic [NUM_LINES-1:0] ack_pulse
);

    reg_dec_t             dec;
    line_cfg_t            cfg_q [NUM_LINES];
    logic [NUM_LINES-1:0] mask_vec;

    assign dec = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= CFG_RESET;
        end else if (wr_en && dec.valid) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (i[5:4] == dec.word) begin
                    case (dec.grp)
                        GRP_MASK: cfg_q[i].mask      <= wdata[i[3:0]];
                        GRP_POL:  cfg_q[i].pol       <= wdata[i[3:0]];
                        GRP_MODE: cfg_q[i].edge_mode <= wdata[i[3:0]];
                        default:  ;
                    endcase
                end
            end
        end
    end

    generate
        if (HAS_ACK) begin : g_ack
            always_comb begin
                ack_pulse = '0;
                if (wr_en && dec.valid && dec.grp == GRP_ACK) begin
                    for (int i = 0; i < NUM_LINES; i++)
                        if (i[5:4] == dec.word) ack_pulse[i] = wdata[i[3:0]];
                end
            end
        end else begin : g_no_ack
            assign ack_pulse = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (dec.valid) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (i[5:4] == dec.word) begin
                    case (dec.grp)
                        GRP_MASK: rdata[i[3:0]] = cfg_q[i].mask;
                        GRP_POL:  rdata[i[3:0]] = cfg_q[i].pol;
                        GRP_MODE: rdata[i[3:0]] = cfg_q[i].edge_mode;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) mask_vec[i] = cfg_q[i].mask;
    end

    assign cfg = cfg_q;

    // R1: every line comes out of reset masked
    p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_vec));

    // R2: malformed address reads zero and a write there leaves the mask alone
    p_bad_addr_read_r2: assert property (@(posedge clk) disable iff (rst)
        !dec.valid |-> (rdata == '0));
    p_bad_addr_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.valid) |=> $stable(mask_vec));

    // R3: acknowledge group reads as zero
    p_ack_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (dec.valid && dec.grp == GRP_ACK) |-> (rdata == '0));

endmodule

// File: rtl/irqb_lines.sv
module irqb_lines
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter bit          HAS_ACK   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] src,
    input  line_cfg_t            cfg [NUM_LINES],
    input  logic [NUM_LINES-1:0] ack_pulse,
    output logic [NUM_LINES-1:0] irq_out
);

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            logic corr;
            logic prev_q;
            logic latch_q;
            logic edge_set;

            assign corr     = src[i] ^ cfg[i].pol;
            assign edge_set = cfg[i].edge_mode & corr & ~prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q  <= 1'b0;
                    latch_q <= 1'b0;
                end else begin
                    prev_q  <= corr;
                    latch_q <= cfg[i].edge_mode & (edge_set | (latch_q & ~ack_pulse[i]));
                end
            end

            assign irq_out[i] = ~cfg[i].mask & (cfg[i].edge_mode ? latch_q : corr);

            // R4: a masked line never drives the parent
            p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
                cfg[i].mask |-> !irq_out[i]);

            // R6: a held edge request stays until acknowledged
            p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (latch_q && cfg[i].edge_mode && !ack_pulse[i]) |=> latch_q);

            // R8: an acknowledge without a coincident edge empties the latch
            p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
                (ack_pulse[i] && !edge_set) |=> !latch_q);

            // R10: level mode keeps the latch empty
            p_level_no_latch_r10: assert property (@(posedge clk) disable iff (rst)
                !cfg[i].edge_mode |=> !latch_q);

            if (!HAS_ACK) begin : g_hold
                // R9: without acknowledge, only a mode change drops a request
                p_noack_hold_r9: assert property (@(posedge clk) disable iff (rst)
                    (latch_q && cfg[i].edge_mode) |=> latch_q);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_level_bridge.sv
module irq_level_bridge
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter bit          HAS_ACK   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_src,
    input  logic [7:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    line_cfg_t            cfg [NUM_LINES];
    logic [NUM_LINES-1:0] ack_pulse;

    initial begin
        if (NUM_LINES < 1 || NUM_LINES > MAX_LINES)
            $error("NUM_LINES must lie in 1..%0d", MAX_LINES);
    end

    irqb_regs #(
        .NUM_LINES(NUM_LINES),
        .HAS_ACK  (HAS_ACK)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .ack_pulse(ack_pulse)
    );

    irqb_lines #(
        .NUM_LINES(NUM_LINES),
        .HAS_ACK  (HAS_ACK)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .src      (irq_src),
        .cfg      (cfg),
        .ack_pulse(ack_pulse),
        .irq_out  (irq_out)
    );

    // R1: outputs are quiet on the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0));

endmodule

// File: tb/irq_level_bridge_tb.sv
module irq_level_bridge_tb;

    localparam int NL  = 40;
    localparam int NL2 = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] src = '0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [NL-1:0] out;

    logic [NL2-1:0] nb_src = '0;
    logic [7:0]     nb_addr = '0;
    logic           nb_wr = 1'b0;
    logic [15:0]    nb_wdata = '0;
    logic [15:0]    nb_rdata;
    logic [NL2-1:0] nb_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    irq_level_bridge #(.NUM_LINES(NL), .HAS_ACK(1'b1)) u_dut (
        .clk(clk), .rst(rst), .irq_src(src), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(out));

    irq_level_bridge #(.NUM_LINES(NL2), .HAS_ACK(1'b0)) u_dut_noack (
        .clk(clk), .rst(rst), .irq_src(nb_src), .reg_addr(nb_addr), .reg_wr(nb_wr),
        .reg_wdata(nb_wdata), .reg_rdata(nb_rdata), .irq_out(nb_out));

    // Model of the main instance, built from the requirements
    logic [NL-1:0] m_mask, m_pol, m_mode, m_latch, m_prev;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NL-1:0] exp_out();
        return ~m_mask & ((m_mode & m_latch) | (~m_mode & (src ^ m_pol)));
    endfunction

    function automatic bit addr_ok(input logic [7:0] a);
        return (a[7:6] == 2'b00) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        logic [15:0] r = '0;
        if (addr_ok(a) && a[5:4] != 2'd2) begin
            for (int i = 0; i < NL; i++) begin
                if (i / 16 == int'(a[3:2])) begin
                    case (a[5:4])
                        2'd0: r[i % 16] = m_mask[i];
                        2'd1: r[i % 16] = m_pol[i];
                        default: r[i % 16] = m_mode[i];
                    endcase
                end
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        m_mask = '1; m_pol = '0; m_mode = '0; m_latch = '0; m_prev = '0;
    endtask

    // Called right after a rising edge, with the inputs that edge sampled
    task automatic model_edge();
        logic [NL-1:0] corr, setv, clr;
        corr = src ^ m_pol;
        setv = m_mode & corr & ~m_prev;
        clr  = '0;
        if (wr && addr_ok(addr) && addr[5:4] == 2'd2)
            for (int i = 0; i < NL; i++)
                if (i / 16 == int'(addr[3:2])) clr[i] = wdata[i % 16];
        m_latch = m_mode & (setv | (m_latch & ~clr));
        m_prev  = corr;
        if (wr && addr_ok(addr)) begin
            for (int i = 0; i < NL; i++) begin
                if (i / 16 == int'(addr[3:2])) begin
                    case (addr[5:4])
                        2'd0: m_mask[i] = wdata[i % 16];
                        2'd1: m_pol[i]  = wdata[i % 16];
                        2'd3: m_mode[i] = wdata[i % 16];
                        default: ;
                    endcase
                end
            end
        end
    endtask

    // Inputs were set just after a falling edge; check, then run one clock.
    task automatic tick(input string req);
        #1;
        chk({req, " irq_out"}, 64'(out), 64'(exp_out()));
        chk({req, " rdata"}, 64'(rdata), 64'(exp_read(addr)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d, input string req);
        addr = a; wdata = d; wr = 1'b1;
        tick(req);
    endtask

    task automatic nb_write(input logic [7:0] a, input logic [15:0] d);
        nb_addr = a; nb_wdata = d; nb_wr = 1'b1;
        @(negedge clk);
        nb_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R3: reset state, readback of partly populated words
        addr = 8'h00; tick("R1");
        addr = 8'h08; tick("R3");
        chk("R3 partial mask word", 64'(exp_read(8'h08)), 64'h00ff);
        addr = 8'h0C; tick("R3");
        addr = 8'h14; tick("R1");
        addr = 8'h34; tick("R1");

        // R5: level pass-through with and without inversion
        for (int w = 0; w < 4; w++) wr_reg(8'(w * 4), 16'h0000, "R4");
        src = 40'h00_1234_5678; addr = 8'h10; tick("R5");
        wr_reg(8'h10, 16'hff00, "R5");
        tick("R5");
        src = 40'hff_0000_ffff; tick("R5");
        wr_reg(8'h10, 16'h0000, "R5");
        src = '0; tick("R5");

        // R4: masking a level line
        src[3] = 1'b1; tick("R4");
        wr_reg(8'h00, 16'h0008, "R4");
        chk("R4 masked line", 64'(out[3]), 64'd0);
        tick("R4");
        src[3] = 1'b0;
        wr_reg(8'h00, 16'h0000, "R4");

        // R6 / R7: edge latched while masked, shown on unmask
        wr_reg(8'h30, 16'h0020, "R6");
        wr_reg(8'h00, 16'h0020, "R7");
        src[5] = 1'b1; tick("R7");
        src[5] = 1'b0; tick("R7");
        chk("R7 latched but masked", 64'(out[5]), 64'd0);
        wr_reg(8'h00, 16'h0000, "R7");
        #1 chk("R7 appears on unmask", 64'(out[5]), 64'd1);
        tick("R6");

        // R8: acknowledge clears, zero bits do nothing
        wr_reg(8'h20, 16'hffdf, "R8");
        chk("R8 zero ack bit", 64'(out[5]), 64'd1);
        wr_reg(8'h20, 16'h0020, "R8");
        chk("R8 ack clears", 64'(out[5]), 64'd0);
        tick("R8");

        // R8: edge and acknowledge on the same clock, edge wins
        src[5] = 1'b1; addr = 8'h20; wdata = 16'h0020; wr = 1'b1; tick("R8");
        chk("R8 set beats clear", 64'(out[5]), 64'd1);
        src[5] = 1'b0; wr_reg(8'h20, 16'h0020, "R8");

        // R6: falling edge through inverted polarity on line 33
        wr_reg(8'h38, 16'h0002, "R6");
        src[33] = 1'b1;
        wr_reg(8'h18, 16'h0002, "R6");
        tick("R6");
        src[33] = 1'b0; tick("R6");
        chk("R6 falling edge latched", 64'(out[33]), 64'd1);
        src[33] = 1'b1; tick("R6");

        // R2: malformed addresses ignored
        wr_reg(8'h41, 16'hffff, "R2");
        wr_reg(8'h02, 16'hffff, "R2");
        wr_reg(8'h80, 16'hffff, "R2");
        addr = 8'h00; tick("R2");
        addr = 8'h42; tick("R2");

        // Random mix of register writes and source activity
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            a = {2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b00};
            if ($urandom_range(0, 15) == 0) a = 8'($urandom);
            addr = a;
            if ($urandom_range(0, 3) == 0) begin
                wdata = 16'($urandom);
                wr = 1'b1;
            end
            if ($urandom_range(0, 1) == 0) src = src ^ NL'({$urandom, $urandom} & {$urandom, $urandom});
            tick("R6");
        end

        // R9 / R10: instance without acknowledge
        nb_write(8'h30, 16'h0008);
        nb_write(8'h00, 16'h0000);
        nb_src[3] = 1'b1; @(negedge clk);
        #1 chk("R6 noack latch", 64'(nb_out[3]), 64'd1);
        nb_src[3] = 1'b0; @(negedge clk);
        #1 chk("R6 noack hold", 64'(nb_out[3]), 64'd1);
        nb_write(8'h20, 16'hffff);
        #1 chk("R9 ack ignored", 64'(nb_out[3]), 64'd1);
        nb_addr = 8'h20; #1 chk("R9 ack reads zero", 64'(nb_rdata), 64'd0);
        nb_write(8'h30, 16'h0000);
        #1 chk("R10 level shows source", 64'(nb_out[3]), 64'd0);
        @(negedge clk);
        nb_write(8'h30, 16'h0008);
        #1 chk("R10 latch dropped", 64'(nb_out[3]), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule